// File: doc/BRIEF.md
# Serial Controller Control-Word Sequencer

This block sits behind the single control address of a programmable serial controller. Every byte written there passes through a small phase machine, which decides what the byte means. The first byte after reset is a mode word. If that mode word picks synchronous framing, a fixed number of sync characters follow. After that, every byte is a command word until a command asks for an internal reset.

The block keeps the decoded mode fields and the stored sync characters, and passes them to the transmit and receive datapaths. Those datapaths are not part of this block. The block also holds the command levels and drives the two active-low modem-control lines. It gives a one-cycle pulse that clears the receiver's error flags.

All outputs come from registers. They change on the clock edge that samples a write strobe, so they are visible in the cycle that follows.

Top module: `ctlword_sequencer`

## Requirements
- R1: After reset, `rts_n` and `dtr_n` are 1 and every other output is 0. The first accepted write is treated as a mode word.
- R2: A write in the mode phase loads the mode fields from these bits: `stop_code` from bits 7:6, `parity_even` from bit 5 (1 = even), `parity_en` from bit 4, `char_len_code` from bits 3:2 (00 = 5 bits up to 11 = 8 bits) and `clk_factor_code` from bits 1:0. The mode fields keep their value until the next mode word.
- R3: If the mode word has a nonzero clock factor (asynchronous), the next write is a command word. Every later write is also a command word.
- R4: If the mode word has clock factor 00 (synchronous), the next SYNC_COUNT writes are sync characters. The k-th one is stored in `sync_chars[8k+7:8k]`, counting from k = 0. The write after the last sync character is a command word.
- R5: A command word with bit 6 set makes the next write a mode word. It returns every command output to its reset value and ignores its other bits. The mode fields and sync characters are kept.
- R6: A command word without bit 6 sets `rts_n` to the inverse of bit 5 and `dtr_n` to the inverse of bit 1. Both hold until the next command word.
- R7: A command word without bit 6 sets these levels, which hold until the next command word: `hunt_en` from bit 7, `break_en` from bit 3, `rx_en` from bit 2 and `tx_en` from bit 0.
- R8: `err_clear` is high for exactly one cycle after a command word that has bit 4 set and bit 6 clear. It is low at all other times.
- R9: With SYNC_COUNT = 2, the sequence of three 0x00 writes followed by 0x40 leaves the block expecting a mode word, whatever phase it started in.
- R10: Bytes presented while `ctl_we` is low change no output and do not advance the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Write strobe for the control address |
| ctl_byte | input | 8 | Byte written to the control address |
| stop_code | output | 2 | Stop-bit code from the mode word |
| parity_even | output | 1 | Parity sense, 1 = even |
| parity_en | output | 1 | Parity enable |
| char_len_code | output | 2 | Character length code, 00 = 5 bits |
| clk_factor_code | output | 2 | Clock factor code, 00 = synchronous |
| sync_chars | output | 8*SYNC_COUNT | Stored sync characters, index 0 in the low byte |
| hunt_en | output | 1 | Hunt level from the command word |
| rts_n | output | 1 | Request-to-send, active low |
| err_clear | output | 1 | One-cycle error-flag clear pulse |
| break_en | output | 1 | Forces the transmit line low |
| rx_en | output | 1 | Receiver enable |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| tx_en | output | 1 | Transmitter enable |

## Verification
The bench runs the recovery sequence from each of the three phases, including the case where one sync character has already been taken. A design that miscounts sync characters ends up taking the 0x40 byte as a sync character or a mode word, and the mode that follows comes out wrong.

It sends a command word that has bit 6 set together with the RTS and error-clear bits. A design that decodes those other bits drives `rts_n` low or raises `err_clear`.

It checks that `err_clear` falls in the idle cycle after its pulse. It also checks that the mode fields survive internal resets and command writes. Finally, it toggles `ctl_byte` while the strobe is low: a design that ignores the strobe changes its outputs or shifts its phase.

// File: rtl/sioseq_pkg.sv
package sioseq_pkg;

  typedef enum logic [1:0] {
    PH_MODE = 2'd0,
    PH_SYNC = 2'd1,
    PH_CMD  = 2'd2
  } phase_e;

  typedef struct packed {
    logic [1:0] stop;
    logic       par_even;
    logic       par_en;
    logic [1:0] len;
    logic [1:0] fac;
  } mode_t;

  typedef struct packed {
    logic hunt;
    logic intrst;
    logic rts;
    logic errclr;
    logic brk;
    logic rxen;
    logic dtr;
    logic txen;
  } cmd_t;

  function automatic mode_t decode_mode(input logic [7:0] b);
    mode_t m;
    m.stop     = b[7:6];
    m.par_even = b[5];
    m.par_en   = b[4];
    m.len      = b[3:2];
    m.fac      = b[1:0];
    return m;
  endfunction

  function automatic cmd_t decode_cmd(input logic [7:0] b);
    cmd_t c;
    c.hunt   = b[7];
    c.intrst = b[6];
    c.rts    = b[5];
    c.errclr = b[4];
    c.brk    = b[3];
    c.rxen   = b[2];
    c.dtr    = b[1];
    c.txen   = b[0];
    return c;
  endfunction

  function automatic logic selects_sync(input logic [7:0] b);
    return (b[1:0] == 2'b00);
  endfunction

endpackage

// File: rtl/sioseq_phase.sv
module sioseq_phase
  import sioseq_pkg::*;
#(
  parameter int SYNC_COUNT = 2,
  parameter int IW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  output logic          mode_we,
  output logic          sync_we,
  output logic          cmd_we,
  output logic [IW-1:0] sync_idx
);

  localparam logic [IW-1:0] LAST_IDX = IW'(SYNC_COUNT - 1);

  phase_e phase_q, phase_d;
  logic [IW-1:0] idx_q, idx_d;
  logic int_rst;
  logic enter_sync;
  logic sync_done;

  assign mode_we    = wr_en && (phase_q == PH_MODE);
  assign sync_we    = wr_en && (phase_q == PH_SYNC);
  assign cmd_we     = wr_en && (phase_q == PH_CMD);
  assign int_rst    = cmd_we && decode_cmd(wr_data).intrst;
  assign enter_sync = mode_we && selects_sync(wr_data);
  assign sync_done  = sync_we && (idx_q == LAST_IDX);
  assign sync_idx   = idx_q;

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    if (mode_we) begin
      phase_d = enter_sync ? PH_SYNC : PH_CMD;
      idx_d   = '0;
    end else if (sync_we) begin
      if (sync_done) phase_d = PH_CMD;
      else           idx_d   = idx_q + 1'b1;
    end else if (int_rst) begin
      phase_d = PH_MODE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_MODE;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mode_we, sync_we, cmd_we}));
  a_r3_async_to_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && !selects_sync(wr_data)) |=> (phase_q == PH_CMD));
  a_r4_sync_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && selects_sync(wr_data)) |=> (phase_q == PH_SYNC && idx_q == '0));
  a_r4_last_sync_to_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done |=> (phase_q == PH_CMD));
  a_r5_intrst_to_mode: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst |=> (phase_q == PH_MODE));
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(phase_q));

endmodule

// File: rtl/sioseq_mode_reg.sv
module sioseq_mode_reg
  import sioseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic [7:0] wr_data,
  output mode_t      mode_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_we) mode_q <= decode_mode(wr_data);
  end

  a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_we |=> $stable(mode_q));
  a_r2_mode_stop_field: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (mode_q.stop == $past(wr_data[7:6])));

endmodule

// File: rtl/sioseq_sync_store.sv
module sioseq_sync_store #(
  parameter int SYNC_COUNT = 2,
  parameter int IW = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sync_we,
  input  logic [IW-1:0]           sync_idx,
  input  logic [7:0]              wr_data,
  output logic [8*SYNC_COUNT-1:0] sync_q
);

  for (genvar k = 0; k < SYNC_COUNT; k++) begin : g_slot
    logic slot_we;
    assign slot_we = sync_we && (sync_idx == IW'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sync_q[8*k +: 8] <= '0;
      else if (slot_we) sync_q[8*k +: 8] <= wr_data;
    end
  end

  a_r4_sync_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_we |=> $stable(sync_q));

endmodule

// File: rtl/sioseq_cmd_reg.sv
module sioseq_cmd_reg
  import sioseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] wr_data,
  output logic       hunt,
  output logic       rts_n,
  output logic       brk,
  output logic       rx_en,
  output logic       dtr_n,
  output logic       tx_en,
  output logic       err_clr
);

  cmd_t c;
  logic do_rst;
  logic do_load;

  assign c       = decode_cmd(wr_data);
  assign do_rst  = cmd_we && c.intrst;
  assign do_load = cmd_we && !c.intrst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hunt <= 1'b0; rts_n <= 1'b1; brk <= 1'b0;
      rx_en <= 1'b0; dtr_n <= 1'b1; tx_en <= 1'b0;
      err_clr <= 1'b0;
    end else begin
      err_clr <= do_load && c.errclr;
      if (do_rst) begin
        hunt <= 1'b0; rts_n <= 1'b1; brk <= 1'b0;
        rx_en <= 1'b0; dtr_n <= 1'b1; tx_en <= 1'b0;
      end else if (do_load) begin
        hunt  <= c.hunt;
        rts_n <= !c.rts;
        brk   <= c.brk;
        rx_en <= c.rxen;
        dtr_n <= !c.dtr;
        tx_en <= c.txen;
      end
    end
  end

  a_r6_rts_follows: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> (rts_n == !$past(wr_data[5])));
  a_r6_dtr_follows: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> (dtr_n == !$past(wr_data[1])));
  a_r5_intrst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    do_rst |=> (rts_n && dtr_n && !rx_en && !tx_en && !brk && !hunt && !err_clr));
  a_r8_errclr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |-> $past(do_load && wr_data[4]));
  a_r7_levels_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> $stable({hunt, brk, rx_en, tx_en, rts_n, dtr_n}));

endmodule

// File: rtl/ctlword_sequencer.sv
module ctlword_sequencer
  import sioseq_pkg::*;
#(
  parameter int SYNC_COUNT = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ctl_we,
  input  logic [7:0]              ctl_byte,
  output logic [1:0]              stop_code,
  output logic                    parity_even,
  output logic                    parity_en,
  output logic [1:0]              char_len_code,
  output logic [1:0]              clk_factor_code,
  output logic [8*SYNC_COUNT-1:0] sync_chars,
  output logic                    hunt_en,
  output logic                    rts_n,
  output logic                    err_clear,
  output logic                    break_en,
  output logic                    rx_en,
  output logic                    dtr_n,
  output logic                    tx_en
);

  localparam int IW = (SYNC_COUNT > 1) ? $clog2(SYNC_COUNT) : 1;

  logic          mode_we;
  logic          sync_we;
  logic          cmd_we;
  logic [IW-1:0] sync_idx;
  mode_t         mode_q;

  sioseq_phase #(.SYNC_COUNT(SYNC_COUNT), .IW(IW)) u_phase (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_we), .wr_data(ctl_byte),
    .mode_we(mode_we), .sync_we(sync_we), .cmd_we(cmd_we), .sync_idx(sync_idx)
  );

  sioseq_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .wr_data(ctl_byte), .mode_q(mode_q)
  );

  sioseq_sync_store #(.SYNC_COUNT(SYNC_COUNT), .IW(IW)) u_sync (
    .clk(clk), .rst_n(rst_n), .sync_we(sync_we), .sync_idx(sync_idx),
    .wr_data(ctl_byte), .sync_q(sync_chars)
  );

  sioseq_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .wr_data(ctl_byte),
    .hunt(hunt_en), .rts_n(rts_n), .brk(break_en), .rx_en(rx_en),
    .dtr_n(dtr_n), .tx_en(tx_en), .err_clr(err_clear)
  );

  assign stop_code       = mode_q.stop;
  assign parity_even     = mode_q.par_even;
  assign parity_en       = mode_q.par_en;
  assign char_len_code   = mode_q.len;
  assign clk_factor_code = mode_q.fac;

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rts_n && dtr_n && !err_clear));

endmodule

// File: tb/test_ctlword_sequencer.sv
`timescale 1ns/100ps
module test_ctlword_sequencer;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0;
  logic [7:0] ctl_byte = 8'h00;
  logic [1:0] stop_code, char_len_code, clk_factor_code;
  logic parity_even, parity_en;
  logic [15:0] sync_chars;
  logic hunt_en, rts_n, err_clear, break_en, rx_en, dtr_n, tx_en;

  always #2.5 clk = ~clk;

  ctlword_sequencer #(.SYNC_COUNT(2)) i_ctlword_sequencer (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_byte(ctl_byte),
    .stop_code(stop_code), .parity_even(parity_even), .parity_en(parity_en),
    .char_len_code(char_len_code), .clk_factor_code(clk_factor_code),
    .sync_chars(sync_chars), .hunt_en(hunt_en), .rts_n(rts_n),
    .err_clear(err_clear), .break_en(break_en), .rx_en(rx_en),
    .dtr_n(dtr_n), .tx_en(tx_en)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // bench model: 0 = expecting mode, 1 = sync, 2 = command
  int   m_phase = 0;
  int   m_scnt = 0;
  logic [7:0] m_mode = 8'h00;
  logic [7:0] m_cmd = 8'h00;
  logic [7:0] m_sync [2] = '{8'h00, 8'h00};
  logic m_err = 1'b0;

  logic [30:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [30:0] model_vec();
    return {m_cmd[7], m_cmd[2], m_cmd[0], m_cmd[3], ~m_cmd[5], ~m_cmd[1], m_err,
            m_mode, m_sync[1], m_sync[0]};
  endfunction

  function automatic logic [30:0] dut_vec();
    return {hunt_en, rx_en, tx_en, break_en, rts_n, dtr_n, err_clear,
            stop_code, parity_even, parity_en, char_len_code, clk_factor_code,
            sync_chars};
  endfunction

  task automatic model_write(input logic [7:0] b);
    m_err = 1'b0;
    case (m_phase)
      0: begin
        m_mode = b;
        if (b[1:0] == 2'b00) begin m_phase = 1; m_scnt = 0; end
        else m_phase = 2;
      end
      1: begin
        m_sync[m_scnt] = b;
        m_scnt++;
        if (m_scnt == 2) m_phase = 2;
      end
      default: begin
        if (b[6]) begin m_cmd = 8'h00; m_phase = 0; end
        else begin m_cmd = b; m_err = b[4]; end
      end
    endcase
  endtask

  task automatic wr(input logic [7:0] b, input string tag);
    ctl_we = 1'b1;
    ctl_byte = b;
    model_write(b);
    #1;
    exp_q.push_back(model_vec());
    tag_q.push_back(tag);
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic idle(input logic [7:0] noise, input string tag);
    ctl_we = 1'b0;
    ctl_byte = noise;
    m_err = 1'b0;
    #1;
    exp_q.push_back(model_vec());
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [30:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      vectors++;
      if (dut_vec() !== e) begin
        miscompares++;
        $display("FAIL %s actual=%h expected=%h", t, dut_vec(), e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog R1..: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(8'h00, "R1 reset state");
    // asynchronous setup
    wr(8'h7A, "R2 mode word load");
    wr(8'h27, "R3 R6 R7 command after async mode");
    wr(8'h12, "R8 error clear with DTR");
    idle(8'h00, "R8 pulse ends after one cycle");
    wr(8'h08, "R7 break level");
    idle(8'h00, "R7 break held");
    wr(8'h85, "R7 hunt rx tx");
    wr(8'h22, "R6 RTS and DTR active");
    // strobe low: data must be ignored
    idle(8'h40, "R10 ignored byte 0x40");
    idle(8'hFF, "R10 ignored byte 0xFF");
    wr(8'h05, "R10 phase unchanged, still command");
    // internal reset with other bits set
    wr(8'h70, "R5 internal reset ignores other bits");
    idle(8'h00, "R5 no error pulse");
    wr(8'h5B, "R5 R2 next write is mode");
    wr(8'h01, "R3 command after reload");
    // synchronous mode
    wr(8'h40, "R5 internal reset");
    wr(8'hCC, "R4 sync mode word");
    wr(8'h16, "R4 first sync char");
    wr(8'h96, "R4 second sync char");
    wr(8'h26, "R4 command after sync chars");
    wr(8'h14, "R8 error clear again");
    wr(8'h14, "R8 back to back error clear");
    idle(8'h00, "R8 pulse ends");
    // recovery from command phase
    wr(8'h00, "R9 zero in command phase");
    wr(8'h00, "R9 zero in command phase");
    wr(8'h00, "R9 zero in command phase");
    wr(8'h40, "R9 reset from command phase");
    wr(8'h4F, "R9 mode after recovery from command");
    wr(8'h25, "R9 command");
    // recovery from mode phase
    wr(8'h40, "R5 internal reset");
    wr(8'h00, "R9 zero as mode word");
    wr(8'h00, "R9 zero as sync char");
    wr(8'h00, "R9 zero as sync char");
    wr(8'h40, "R9 reset from mode phase");
    wr(8'hFE, "R9 mode after recovery from mode");
    wr(8'h02, "R9 command");
    // recovery from sync phase with one character taken
    wr(8'h40, "R5 internal reset");
    wr(8'h8C, "R4 sync mode word");
    wr(8'hAA, "R4 one sync char");
    wr(8'h00, "R9 zero as last sync char");
    wr(8'h00, "R9 zero as command");
    wr(8'h00, "R9 zero as command");
    wr(8'h40, "R9 reset from sync phase");
    wr(8'h4E, "R9 mode after recovery from sync");
    wr(8'h02, "R9 command");
    idle(8'h00, "R7 final hold");
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule